// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Protocol Engine

This block is the bus-side protocol engine of a byte-addressed serial memory that answers on a two-wire clock/data bus. It runs on a fast system clock. SCL and SDA reach it already synchronised, and it finds clock edges and START/STOP conditions by comparing each sample with the one before. The block never drives SDA high. It asserts an open-drain enable that pulls the line low, either to acknowledge or to send a zero bit.

A transaction starts with a command byte. The upper nibble `1010` selects the device, and bit 0 selects write (0) or read (1). For a write, bit 1 of the command byte is the top address bit, and the byte after it loads the lower eight bits of a 9-bit address counter. Each data byte that follows goes out as a single-cycle write request to the page programming unit. A STOP then starts programming with a commit pulse.

For a read, the engine fetches bytes through a synchronous read port and shifts them out MSB first. It continues while the master acknowledges. The address counter is kept between transactions, so a read that sends no address continues from where the last transfer stopped.

Top module: `serial_mem_slave`

## Requirements
- R1: After reset the SDA pull-down enable is low and no read, write or commit pulse is issued.
- R2: A command byte whose bits 7..4 are `1010` is acknowledged. Bits 3..1 of a read command are ignored, and bits 3..2 of a write command are ignored. A command byte with any other upper nibble is not acknowledged, and every following byte is ignored until the next START.
- R3: While `prog_busy_i` is high, no command byte is acknowledged.
- R4: In a write command (bit 0 = 0), bit 1 sets address bit 8. The next byte sets address bits 7..0 and is acknowledged. Each later byte is acknowledged and produces one `wr_req_o` pulse carrying the current address and the received data.
- R5: During a write, the address advances only in bits 3..0, wrapping within its 16-byte page. Bits 8..4 do not change.
- R6: A STOP after at least one written data byte gives exactly one `wr_commit_o` pulse. A START in place of that STOP gives no commit.
- R7: Read data is sent MSB first. The pull-down enable changes only while SCL is low. The slave acknowledges a read command and releases SDA during the master's acknowledge clock.
- R8: A repeated START after the address byte of a write, followed by a read command, reads from the address just loaded.
- R9: A read without an address starts at the counter value left by the previous transfer, which is one past the last byte read or written.
- R10: Each byte sent increments the full 9-bit counter, and the counter wraps from 511 to 0. The slave keeps sending while the master acknowledges.
- R11: A byte the master does not acknowledge ends the read. The slave then releases SDA and ignores further clocks until the next START.
- R12: A START in any state, including in the middle of a byte, returns the engine to receiving a command byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised serial clock |
| sda_i | input | 1 | Synchronised serial data line as seen on the bus |
| sda_oe_o | output | 1 | Pull SDA low when high |
| prog_busy_i | input | 1 | Programming cycle in progress |
| rd_en_o | output | 1 | Read strobe to the array |
| rd_addr_o | output | ADDR_W | Read address |
| rd_data_i | input | 8 | Read data, valid the cycle after `rd_en_o` |
| wr_req_o | output | 1 | One data byte for the page buffer |
| wr_addr_o | output | ADDR_W | Address of that byte |
| wr_data_o | output | 8 | Data of that byte |
| wr_commit_o | output | 1 | Start the programming cycle |

## Verification
The bench builds the block with its defaults: a 9-bit address and 16-byte pages. With these values, a random read starting near address 510 reaches the wrap from 511 to 0 within three bytes. A three-byte page write starting at offset 14 crosses the page-wrap boundary. The scoreboard compares every write request against the wrapped address predicted from the page rule, and applies it to the memory model only on commit. Read-back then shows both committed data and data discarded by an abort.

// File: rtl/serial_mem_pkg.sv
package serial_mem_pkg;

    localparam int BYTE_W  = 8;
    localparam int BITCT_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA
    } sm_state_e;

endpackage

// File: rtl/serial_mem_bus_events.sv
module serial_mem_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic scl;
        logic sda;
    } ev_regs_t;

    ev_regs_t ev_d, ev_q;

    always_comb begin
        ev_d     = ev_q;
        ev_d.scl = scl_i;
        ev_d.sda = sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            ev_q <= ev_d;
        end
    end

    // START and STOP need SCL high in both samples.
    assign scl_rise_o = scl_i & ~ev_q.scl;
    assign scl_fall_o = ~scl_i & ev_q.scl;
    assign start_o    = scl_i & ev_q.scl & ev_q.sda & ~sda_i;
    assign stop_o     = scl_i & ev_q.scl & ~ev_q.sda & sda_i;

endmodule

// File: rtl/serial_mem_addr_ctr.sv
module serial_mem_addr_ctr #(
    parameter int ADDR_W = 9,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_hi_i,
    input  logic              hi_bit_i,
    input  logic              set_lo_i,
    input  logic [ADDR_W-2:0] lo_i,
    input  logic              inc_lin_i,
    input  logic              inc_page_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int HI_W = ADDR_W - PAGE_W;

    logic [ADDR_W-1:0] addr_d, addr_q;
    logic [PAGE_W-1:0] page_off;

    always_comb begin
        addr_d   = addr_q;
        page_off = addr_q[PAGE_W-1:0] + 1'b1;
        if (set_hi_i) begin
            addr_d[ADDR_W-1] = hi_bit_i;
        end else if (set_lo_i) begin
            addr_d[ADDR_W-2:0] = lo_i;
        end else if (inc_lin_i) begin
            addr_d = addr_q + 1'b1;
        end else if (inc_page_i) begin
            addr_d = {addr_q[ADDR_W-1:PAGE_W], page_off};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    assign addr_o = addr_q;

    // R10: a read step moves the whole counter by one and wraps at the top
    a_r10_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_lin_i && !set_hi_i && !set_lo_i) |=> addr_o == ADDR_W'($past(addr_o) + 1'b1));

    // R5: a write step leaves the page bits untouched
    a_r5_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_page_i && !inc_lin_i && !set_hi_i && !set_lo_i)
        |=> addr_o[ADDR_W-1:PAGE_W] == HI_W'($past(addr_o[ADDR_W-1:PAGE_W])));

endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave
    import serial_mem_pkg::*;
#(
    parameter int         ADDR_W  = 9,
    parameter int         PAGE_W  = 4,
    parameter logic [3:0] DEV_TAG = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic              prog_busy_i,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [7:0]        rd_data_i,
    output logic              wr_req_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [7:0]        wr_data_o,
    output logic              wr_commit_o
);

    localparam int LO_W = ADDR_W - 1;
    localparam logic [BITCT_W-1:0] ACK_SLOT = BITCT_W'(BYTE_W);
    localparam logic [BITCT_W-1:0] ACK_DONE = BITCT_W'(BYTE_W + 1);

    typedef struct packed {
        sm_state_e          st;
        logic [BITCT_W-1:0] bitcnt;
        logic [7:0]         rx;
        logic [7:0]         tx;
        logic               oe;
        logic               mack;
        logic               wr_any;
        logic               rd_wait;
        logic               rd_en;
        logic [ADDR_W-1:0]  rd_addr;
        logic               wr_req;
        logic [ADDR_W-1:0]  wr_addr;
        logic [7:0]         wr_data;
        logic               commit;
    } sm_regs_t;

    sm_regs_t sm_d, sm_q;

    logic ev_rise, ev_fall, ev_start, ev_stop;
    logic set_hi, hi_bit, set_lo, inc_lin, inc_page;
    logic [LO_W-1:0]   lo_val;
    logic [ADDR_W-1:0] addr;

    serial_mem_bus_events u_events (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (ev_rise),
        .scl_fall_o (ev_fall),
        .start_o    (ev_start),
        .stop_o     (ev_stop)
    );

    serial_mem_addr_ctr #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W)
    ) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_hi_i   (set_hi),
        .hi_bit_i   (hi_bit),
        .set_lo_i   (set_lo),
        .lo_i       (lo_val),
        .inc_lin_i  (inc_lin),
        .inc_page_i (inc_page),
        .addr_o     (addr)
    );

    always_comb begin
        sm_d         = sm_q;
        sm_d.rd_en   = 1'b0;
        sm_d.wr_req  = 1'b0;
        sm_d.commit  = 1'b0;
        sm_d.rd_wait = sm_q.rd_en;
        set_hi   = 1'b0;
        hi_bit   = 1'b0;
        set_lo   = 1'b0;
        lo_val   = LO_W'(sm_q.rx);
        inc_lin  = 1'b0;
        inc_page = 1'b0;

        // array data arrives one cycle after the strobe
        if (sm_q.rd_wait) begin
            sm_d.tx = rd_data_i;
        end

        if (ev_start) begin
            sm_d.st     = ST_CMD;
            sm_d.bitcnt = '0;
            sm_d.oe     = 1'b0;
            sm_d.wr_any = 1'b0;
        end else if (ev_stop) begin
            sm_d.commit = (sm_q.st == ST_WDATA) && sm_q.wr_any;
            sm_d.st     = ST_IDLE;
            sm_d.oe     = 1'b0;
            sm_d.wr_any = 1'b0;
        end else if (sm_q.st != ST_IDLE) begin
            if (ev_rise) begin
                if (sm_q.bitcnt < ACK_SLOT) begin
                    sm_d.rx     = {sm_q.rx[6:0], sda_i};
                    sm_d.bitcnt = sm_q.bitcnt + 1'b1;
                end else if (sm_q.bitcnt == ACK_SLOT) begin
                    sm_d.bitcnt = ACK_DONE;
                    // master acknowledge after a transmitted byte
                    if (sm_q.st == ST_RDATA && !sm_q.oe) begin
                        sm_d.mack = ~sda_i;
                        if (!sda_i) begin
                            sm_d.rd_en   = 1'b1;
                            sm_d.rd_addr = addr;
                            inc_lin      = 1'b1;
                        end
                    end
                end
            end else if (ev_fall) begin
                if (sm_q.bitcnt == ACK_SLOT) begin
                    unique case (sm_q.st)
                        ST_CMD: begin
                            if (sm_q.rx[7:4] == DEV_TAG && !prog_busy_i) begin
                                sm_d.oe = 1'b1;
                                if (sm_q.rx[0]) begin
                                    sm_d.st      = ST_RDATA;
                                    sm_d.rd_en   = 1'b1;
                                    sm_d.rd_addr = addr;
                                    inc_lin      = 1'b1;
                                end else begin
                                    sm_d.st = ST_ADDR;
                                    set_hi  = 1'b1;
                                    hi_bit  = sm_q.rx[1];
                                end
                            end else begin
                                sm_d.st = ST_IDLE;
                            end
                        end
                        ST_ADDR: begin
                            sm_d.oe = 1'b1;
                            set_lo  = 1'b1;
                            sm_d.st = ST_WDATA;
                        end
                        ST_WDATA: begin
                            sm_d.oe      = 1'b1;
                            sm_d.wr_req  = 1'b1;
                            sm_d.wr_addr = addr;
                            sm_d.wr_data = sm_q.rx;
                            sm_d.wr_any  = 1'b1;
                            inc_page     = 1'b1;
                        end
                        ST_RDATA: begin
                            sm_d.oe = 1'b0;
                        end
                        default: begin
                            sm_d.oe = 1'b0;
                        end
                    endcase
                end else if (sm_q.bitcnt == ACK_DONE) begin
                    sm_d.bitcnt = '0;
                    if (sm_q.st == ST_RDATA) begin
                        if (sm_q.oe || sm_q.mack) begin
                            sm_d.oe = ~sm_q.tx[7];
                        end else begin
                            sm_d.st = ST_IDLE;
                            sm_d.oe = 1'b0;
                        end
                    end else begin
                        sm_d.oe = 1'b0;
                    end
                end else if (sm_q.bitcnt != '0 && sm_q.st == ST_RDATA) begin
                    sm_d.oe = ~sm_q.tx[3'd7 - sm_q.bitcnt[2:0]];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sm_q    <= '0;
            sm_q.st <= ST_IDLE;
        end else begin
            sm_q <= sm_d;
        end
    end

    assign sda_oe_o    = sm_q.oe;
    assign rd_en_o     = sm_q.rd_en;
    assign rd_addr_o   = sm_q.rd_addr;
    assign wr_req_o    = sm_q.wr_req;
    assign wr_addr_o   = sm_q.wr_addr;
    assign wr_data_o   = sm_q.wr_data;
    assign wr_commit_o = sm_q.commit;

    // R11: an idle engine never holds the line
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (sm_q.st == ST_IDLE) |-> !sda_oe_o);

    // R7: the pull-down only moves while the clock is low
    a_r7_move_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o)) |-> !scl_i);

    // R3: no acknowledge of a command during programming
    a_r3_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_busy_i && ev_fall && !ev_start && !ev_stop && sm_q.st == ST_CMD && sm_q.bitcnt == ACK_SLOT)
        |=> !sda_oe_o && sm_q.st == ST_IDLE);

    // R2: a foreign device tag leaves the bus alone
    a_r2_tag_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_fall && !ev_start && !ev_stop && sm_q.st == ST_CMD && sm_q.bitcnt == ACK_SLOT && sm_q.rx[7:4] != DEV_TAG)
        |=> !sda_oe_o);

    // R4: write requests only come out of the data phase
    a_r4_req_in_data: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o |-> sm_q.st == ST_WDATA);

    // R6: a commit is a single pulse
    a_r6_commit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit_o |=> !wr_commit_o);

endmodule

// File: tb/serial_mem_slave_bench.sv
module serial_mem_slave_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int AW         = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic busy = 1'b0;
    logic sda_oe, rd_en, wr_req, wr_commit;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [7:0] rd_data = 8'h00;
    logic [7:0] wr_data;
    wire sda_line = sda_m & ~sda_oe;

    serial_mem_slave u_serial_mem_slave (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl),
        .sda_i       (sda_line),
        .sda_oe_o    (sda_oe),
        .prog_busy_i (busy),
        .rd_en_o     (rd_en),
        .rd_addr_o   (rd_addr),
        .rd_data_i   (rd_data),
        .wr_req_o    (wr_req),
        .wr_addr_o   (wr_addr),
        .wr_data_o   (wr_data),
        .wr_commit_o (wr_commit)
    );

    logic [7:0] mem [512];
    int n_chk = 0;
    int n_fail = 0;
    int commit_cnt = 0;
    logic [16:0] exp_q [$];
    logic [16:0] stage_q [$];
    logic [16:0] got;

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = 8'(i * 7 + 3);
    end

    always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on each write request, applies on commit
    always @(negedge clk) begin
        if (wr_req) begin
            got = {wr_addr, wr_data};
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected write request", int'(got), 0);
            end else begin
                logic [16:0] e;
                e = exp_q.pop_front();
                check(got == e, "R4/R5 write request addr/data", int'(got), int'(e));
            end
            stage_q.push_back(got);
        end
        if (wr_commit) begin
            commit_cnt++;
            foreach (stage_q[k]) mem[stage_q[k][16:8]] = stage_q[k][7:0];
            stage_q.delete();
        end
        if (!wr_req && !rd_en && !wr_commit && !rst_n) stage_q.delete();
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; tick(HALF);
        scl = 1'b1;   tick(HALF);
        sda_m = 1'b0; tick(HALF);
        scl = 1'b0;   tick(2);
        stage_q.delete();
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(HALF);
        scl = 1'b1;   tick(HALF);
        sda_m = 1'b1; tick(HALF);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; tick(HALF);
        scl = 1'b1; tick(HALF);
        scl = 1'b0; tick(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; tick(HALF);
        scl = 1'b1; tick(HALF/2);
        acked = ~sda_line;
        tick(HALF/2);
        scl = 1'b0; tick(2);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(HALF);
            scl = 1'b1; tick(HALF/2);
            b[i] = sda_line;
            tick(HALF/2);
            scl = 1'b0; tick(2);
        end
        sda_m = ~give_ack; tick(HALF);
        scl = 1'b1; tick(HALF);
        scl = 1'b0; tick(2);
        sda_m = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        logic ak;
        logic [7:0] b;
        logic [7:0] e;
        int c0;

        tick(5);
        rst_n = 1'b1;
        tick(3);
        // R1 reset state
        check(!sda_oe && !rd_en && !wr_req && !wr_commit, "R1 outputs idle after reset",
              {sda_oe, rd_en, wr_req, wr_commit}, 0);

        // page write at 0x12E: three bytes wrap to 0x120 (R4, R5, R6)
        bus_start();
        send_byte(8'hA2, ak); check(ak, "R2 write command acked", ak, 1);
        send_byte(8'h2E, ak); check(ak, "R4 address byte acked", ak, 1);
        exp_q.push_back({9'h12E, 8'h11});
        exp_q.push_back({9'h12F, 8'h22});
        exp_q.push_back({9'h120, 8'h33});
        send_byte(8'h11, ak); check(ak, "R4 data byte acked", ak, 1);
        send_byte(8'h22, ak);
        send_byte(8'h33, ak);
        bus_stop();
        tick(3);
        check(commit_cnt == 1, "R6 commit after stop", commit_cnt, 1);
        check(exp_q.size() == 0, "R5 all page requests seen", exp_q.size(), 0);

        // random read from 0x12E, sequential into 0x130 (R8, R10, R7, R2 don't-cares)
        bus_start();
        send_byte(8'hA2, ak);
        send_byte(8'h2E, ak);
        bus_start();
        send_byte(8'hAF, ak); check(ak, "R2 read command with don't-care bits acked", ak, 1);
        recv_byte(1'b1, b); check(b == 8'h11, "R8 random read first byte", b, 8'h11);
        recv_byte(1'b1, b); check(b == 8'h22, "R10 sequential second byte", b, 8'h22);
        recv_byte(1'b0, b); e = mem[9'h130];
        check(b == e, "R10 linear step past page", b, e);
        bus_stop();
        check(commit_cnt == 1, "R6 no commit without data", commit_cnt, 1);

        // current-address read continues at 0x131 (R9)
        bus_start();
        send_byte(8'hA1, ak);
        recv_byte(1'b0, b); e = mem[9'h131];
        check(b == e, "R9 current address read", b, e);
        bus_stop();

        // write then repeated start: no commit, counter at 0x006 (R6, R9)
        bus_start();
        send_byte(8'hA0, ak);
        send_byte(8'h05, ak);
        exp_q.push_back({9'h005, 8'h99});
        send_byte(8'h99, ak);
        c0 = commit_cnt;
        bus_start();
        send_byte(8'hA1, ak);
        recv_byte(1'b0, b); e = mem[9'h006];
        check(b == e, "R9 read after aborted write", b, e);
        bus_stop();
        bus_start();
        send_byte(8'hA0, ak);
        send_byte(8'h05, ak);
        bus_start();
        send_byte(8'hA1, ak);
        recv_byte(1'b0, b);
        check(b == 8'(5 * 7 + 3), "R6 aborted byte not programmed", b, 8'(5 * 7 + 3));
        bus_stop();
        check(commit_cnt == c0, "R6 abort gives no commit", commit_cnt, c0);

        // wrap 511 -> 0 (R10)
        bus_start();
        send_byte(8'hA2, ak);
        send_byte(8'hFE, ak);
        bus_start();
        send_byte(8'hA1, ak);
        recv_byte(1'b1, b); e = mem[9'h1FE]; check(b == e, "R10 byte 510", b, e);
        recv_byte(1'b1, b); e = mem[9'h1FF]; check(b == e, "R10 byte 511", b, e);
        recv_byte(1'b0, b); e = mem[9'h000]; check(b == e, "R10 wrap to 0", b, e);
        bus_stop();

        // busy: no ack (R3)
        busy = 1'b1;
        bus_start();
        send_byte(8'hA1, ak); check(!ak, "R3 no ack while busy", ak, 0);
        bus_stop();
        busy = 1'b0;
        bus_start();
        send_byte(8'hA1, ak); check(ak, "R3 ack after busy clears", ak, 1);
        recv_byte(1'b0, b);
        bus_stop();

        // foreign tag: ignored until START (R2)
        bus_start();
        send_byte(8'hB1, ak); check(!ak, "R2 foreign tag not acked", ak, 0);
        send_byte(8'hA0, ak); check(!ak, "R2 later byte ignored", ak, 0);
        send_byte(8'h00, ak); check(!ak, "R2 further byte ignored", ak, 0);
        bus_stop();
        check(exp_q.size() == 0, "R2 no write from ignored bytes", exp_q.size(), 0);

        // no master ack ends the read (R11)
        bus_start();
        send_byte(8'hA1, ak);
        recv_byte(1'b0, b);
        recv_byte(1'b0, b); check(b == 8'hFF, "R11 line released after nack", b, 8'hFF);
        bus_stop();

        // START in the middle of a byte (R12)
        bus_start();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_start();
        send_byte(8'hA1, ak); check(ak, "R12 restart mid byte", ak, 1);
        recv_byte(1'b0, b);
        bus_stop();

        tick(10);
        check(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule